// File: doc/BRIEF.md
# LIN slave frame controller

This block is the protocol sequencer of a LIN slave node. It sits above a byte-level UART whose transmit line is looped back onto its receive line, so every byte the node sends also comes back as a received byte. The UART reports a break as a one-cycle `brk_seen` pulse, with `brk_ok` high when the break was long enough. The sequencer then expects the sync character 0x55 and the protected identifier. It checks the identifier's parity and offers the 6-bit identifier to an external lookup, which answers in the same cycle with a direction and a data byte count.

In the receive direction the data bytes go into an external buffer at ascending addresses, and the trailing checksum byte is compared with the checksum the block computes. In the transmit direction buffer bytes are sent one at a time. Each next byte, and finally the checksum, is issued only after the echo of the previous byte has matched what was sent. Errors and completions are kept in sticky flags that the host clears. While any error flag is set, the block ignores the bus. When the bus is asleep the node may also send a wake-up character.

Top module: `lin_slave_ctrl`

## Requirements
- R1: Every byte sent on `tx_byte` is compared with the next `rx_byte` the UART delivers. On a mismatch the block sets error bit 0 (bit error) and returns to idle.
- R2: The header is accepted only in the order valid break, sync byte 0x55, identifier. A break with `brk_ok` low, or a sync byte other than 0x55, sets error bit 1 (sync error) and returns to idle. A valid break restarts the header from any state.
- R3: The identifier byte holds the id in bits 5:0, P0 in bit 6 and P1 in bit 7, with P0 = id0^id1^id2^id4 and P1 = ~(id1^id3^id4^id5). A parity mismatch sets error bit 2 and aborts the frame.
- R4: While the identifier byte is on `rx_byte`, `lk_id` carries its bits 5:0, and the lookup answers with `lk_tx` (1 = transmit) and `lk_len`. A count of zero ends the frame silently. A count above MAX_LEN is limited to MAX_LEN.
- R5: In receive mode each data byte is written with `buf_we` to addresses 0, 1, 2 and so on. The byte after the last data byte is checked as the checksum, and a mismatch sets error bit 3.
- R6: In transmit mode `buf_rdata` at address 0 is sent in the same cycle that the identifier is accepted. Each further byte, and then the checksum, is sent in the cycle its predecessor's echo is received.
- R7: `rx_done` and `tx_done` are set on error-free completion of a receive or transmit frame. They hold until `done_clr` is pulsed.
- R8: `err_flags` bits are sticky until `err_clr`. While any bit is set, breaks, bytes and wake requests are ignored: there is no `tx_valid`, no `buf_we` and no busy.
- R9: A wake request sends 0x80 only when the sequencer is idle, no error is set and `bus_asleep` is high. Its echo is checked as in R1.
- R10: `busy` is high from the cycle after a valid break, or after a wake-up character is sent, until the sequencer returns to idle.
- R11: The checksum is the data-byte sum modulo 256 with end-around carry, inverted. The identifier is not included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_seen | input | 1 | Break detected by the UART (one-cycle pulse) |
| brk_ok | input | 1 | Break length valid, qualifies brk_seen |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Byte to transmit, one-cycle strobe |
| tx_byte | output | 8 | Byte to transmit |
| lk_id | output | 6 | Identifier offered to the lookup |
| lk_tx | input | 1 | Lookup answer: 1 = transmit, 0 = receive |
| lk_len | input | CNT_W | Lookup answer: data byte count |
| buf_addr | output | AW | Buffer address |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data, combinational from buf_addr |
| bus_asleep | input | 1 | Bus is in sleep, wake-up allowed |
| wake_req | input | 1 | Request to send a wake-up character |
| err_clr | input | 1 | Clear all error flags |
| done_clr | input | 1 | Clear both completion flags |
| err_flags | output | 4 | Sticky errors: bit0 bit, bit1 sync, bit2 parity, bit3 checksum |
| rx_done | output | 1 | Receive frame completed |
| tx_done | output | 1 | Transmit frame completed |
| busy | output | 1 | Sequencer not idle |

## Verification
A wrong sequencer state shows at the ports within one byte strobe. A missed or extra data byte moves the checksum exchange: the transmit direction sends a checksum where a data byte belonged, or the receive direction flags a checksum error and withholds `rx_done`. A corrupted running sum appears in the next checksum byte that is sent or compared. A failure to block after an error shows as a `tx_valid`, `buf_we` or `busy` pulse on the first later break or byte. The bench therefore checks flags, echoed transmit bytes and buffer contents right after the byte that should have changed them.

// File: rtl/lin_slv_pkg.sv
package lin_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_PID, ST_RXD, ST_RXC, ST_TXD, ST_TXC, ST_WAKE
  } lin_st_e;

  localparam int ERR_W    = 4;
  localparam int ERR_BIT  = 0;
  localparam int ERR_SYNC = 1;
  localparam int ERR_PAR  = 2;
  localparam int ERR_CKS  = 3;

  localparam logic [7:0] SYNC_CHAR = 8'h55;
  localparam logic [7:0] WAKE_CHAR = 8'h80;
endpackage

// File: rtl/lin_pid_check.sv
module lin_pid_check (
  input  logic [7:0] pid,
  output logic [5:0] id,
  output logic       par_ok
);
  logic p0, p1;

  always_comb begin
    id     = pid[5:0];
    p0     = pid[0] ^ pid[1] ^ pid[2] ^ pid[4];
    p1     = ~(pid[1] ^ pid[3] ^ pid[4] ^ pid[5]);
    par_ok = (pid[6] == p0) && (pid[7] == p1);
  end
endmodule

// File: rtl/lin_cks_acc.sv
module lin_cks_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic [W-1:0] din,
  output logic [W-1:0] sum_q,
  output logic [W-1:0] sum_nx
);
  logic [W:0]   raw;
  logic [W-1:0] sum_d;

  always_comb begin
    raw    = {1'b0, sum_q} + {1'b0, din};
    sum_nx = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    sum_d  = sum_q;
    if (clr)      sum_d = '0;
    else if (add) sum_d = sum_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  AST_CKS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_q == '0)); // R11
endmodule

// File: rtl/lin_slave_ctrl.sv
module lin_slave_ctrl
  import lin_slv_pkg::*;
#(
  parameter  int MAX_LEN = 8,
  localparam int CNT_W   = $clog2(MAX_LEN + 1),
  localparam int AW      = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brk_seen,
  input  logic             brk_ok,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic [5:0]       lk_id,
  input  logic             lk_tx,
  input  logic [CNT_W-1:0] lk_len,
  output logic [AW-1:0]    buf_addr,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  input  logic [7:0]       buf_rdata,
  input  logic             bus_asleep,
  input  logic             wake_req,
  input  logic             err_clr,
  input  logic             done_clr,
  output logic [ERR_W-1:0] err_flags,
  output logic             rx_done,
  output logic             tx_done,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LEN);
  localparam logic [AW-1:0]    ONE_A = AW'(1);

  lin_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    idx_q, idx_d;
  logic [7:0]       hold_q, hold_d;
  logic [ERR_W-1:0] err_q, err_d, new_err;
  logic             rxd_q, rxd_d, txd_q, txd_d;
  logic             fin_rx, fin_tx, active, pid_ok;
  logic             acc_clr, acc_add;
  logic [7:0]       sum_q, sum_nx;

  lin_pid_check u_pid (
    .pid    (rx_byte),
    .id     (lk_id),
    .par_ok (pid_ok)
  );

  lin_cks_acc #(.W(8)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (acc_clr),
    .add    (acc_add),
    .din    (rx_byte),
    .sum_q  (sum_q),
    .sum_nx (sum_nx)
  );

  assign active    = (err_q == '0);
  assign buf_wdata = rx_byte;
  assign buf_addr  = (st_q == ST_TXD) ? idx_q + ONE_A : idx_q;

  // next-state process
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    hold_d   = hold_q;
    new_err  = '0;
    fin_rx   = 1'b0;
    fin_tx   = 1'b0;
    tx_valid = 1'b0;
    tx_byte  = hold_q;
    buf_we   = 1'b0;
    acc_clr  = 1'b0;
    acc_add  = 1'b0;
    if (!active) begin
      st_d = ST_IDLE;
    end else if (brk_seen) begin
      if (brk_ok) begin
        st_d    = ST_SYNC;
        idx_d   = '0;
        acc_clr = 1'b1;
      end else begin
        new_err[ERR_SYNC] = 1'b1;
        st_d              = ST_IDLE;
      end
    end else begin
      case (st_q)
        ST_IDLE: if (wake_req && bus_asleep) begin
          tx_valid = 1'b1;
          tx_byte  = WAKE_CHAR;
          hold_d   = WAKE_CHAR;
          st_d     = ST_WAKE;
        end
        ST_SYNC: if (rx_valid) begin
          if (rx_byte == SYNC_CHAR) st_d = ST_PID;
          else begin
            new_err[ERR_SYNC] = 1'b1;
            st_d              = ST_IDLE;
          end
        end
        ST_PID: if (rx_valid) begin
          if (!pid_ok) begin
            new_err[ERR_PAR] = 1'b1;
            st_d             = ST_IDLE;
          end else if (lk_len == '0) begin
            st_d = ST_IDLE;
          end else begin
            cnt_d = (lk_len > MAX_C) ? MAX_C : lk_len;
            if (lk_tx) begin
              tx_valid = 1'b1;
              tx_byte  = buf_rdata;
              hold_d   = buf_rdata;
              st_d     = ST_TXD;
            end else begin
              st_d = ST_RXD;
            end
          end
        end
        ST_RXD: if (rx_valid) begin
          buf_we  = 1'b1;
          acc_add = 1'b1;
          idx_d   = idx_q + ONE_A;
          cnt_d   = cnt_q - ONE_C;
          if (cnt_q == ONE_C) st_d = ST_RXC;
        end
        ST_RXC: if (rx_valid) begin
          if (rx_byte == ~sum_q) fin_rx = 1'b1;
          else                   new_err[ERR_CKS] = 1'b1;
          st_d = ST_IDLE;
        end
        ST_TXD: if (rx_valid) begin
          if (rx_byte != hold_q) begin
            new_err[ERR_BIT] = 1'b1;
            st_d             = ST_IDLE;
          end else begin
            acc_add  = 1'b1;
            idx_d    = idx_q + ONE_A;
            cnt_d    = cnt_q - ONE_C;
            tx_valid = 1'b1;
            if (cnt_q == ONE_C) begin
              tx_byte = ~sum_nx;
              hold_d  = ~sum_nx;
              st_d    = ST_TXC;
            end else begin
              tx_byte = buf_rdata;
              hold_d  = buf_rdata;
            end
          end
        end
        ST_TXC, ST_WAKE: if (rx_valid) begin
          if (rx_byte != hold_q)  new_err[ERR_BIT] = 1'b1;
          else if (st_q == ST_TXC) fin_tx = 1'b1;
          st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
    err_d = (err_clr ? '0 : err_q) | new_err;
    rxd_d = fin_rx | (rxd_q & ~done_clr);
    txd_d = fin_tx | (txd_q & ~done_clr);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      hold_q <= '0;
      err_q  <= '0;
      rxd_q  <= 1'b0;
      txd_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      hold_q <= hold_d;
      err_q  <= err_d;
      rxd_q  <= rxd_d;
      txd_q  <= txd_d;
    end
  end

  assign err_flags = err_q;
  assign rx_done   = rxd_q;
  assign tx_done   = txd_q;
  assign busy      = (st_q != ST_IDLE);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != '0) |-> (!tx_valid && !buf_we)); // R8
  AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && st_q == ST_IDLE) |-> (bus_asleep && tx_byte == WAKE_CHAR)); // R9
  AST_RXDONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !done_clr) |=> rx_done); // R7
  AST_TXDONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !done_clr) |=> tx_done); // R7
  AST_WE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> rx_valid); // R5
  AST_BUSY_AFTER_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_seen && brk_ok && err_flags == '0) |=> busy); // R10
endmodule

// File: tb/lin_slave_ctrl_bench.sv
`timescale 1ns/1ps
module lin_slave_ctrl_bench;
  localparam int MAX_LEN = 8;
  localparam int CNT_W   = 4;
  localparam int AW      = 3;
  localparam int NV      = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic brk_seen, brk_ok, rx_valid, tx_valid, lk_tx, buf_we;
  logic bus_asleep, wake_req, err_clr, done_clr, rx_done, tx_done, busy;
  logic [7:0] rx_byte, tx_byte, buf_wdata, buf_rdata;
  logic [5:0] lk_id;
  logic [CNT_W-1:0] lk_len;
  logic [AW-1:0] buf_addr;
  logic [3:0] err_flags;
  logic [7:0] mem [MAX_LEN];

  int n_chk = 0, n_bad = 0;
  logic got_tx;
  logic [7:0] got_b;
  logic [5:0] got_id;

  always #2.5 clk = ~clk;

  lin_slave_ctrl #(.MAX_LEN(MAX_LEN)) u_lin_slave_ctrl (
    .clk(clk), .rst_n(rst_n), .brk_seen(brk_seen), .brk_ok(brk_ok),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .lk_id(lk_id), .lk_tx(lk_tx), .lk_len(lk_len), .buf_addr(buf_addr),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .bus_asleep(bus_asleep), .wake_req(wake_req), .err_clr(err_clr),
    .done_clr(done_clr), .err_flags(err_flags), .rx_done(rx_done),
    .tx_done(tx_done), .busy(busy)
  );

  // bench lookup: id bit5 selects transmit, id bits 2:0 give the count
  assign lk_tx     = lk_id[5];
  assign lk_len    = {1'b0, lk_id[2:0]};
  assign buf_rdata = mem[buf_addr];
  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  // {sync, bad parity, id, data bytes (first in low byte), checksum xor, exp err, exp rx_done}
  localparam logic [59:0] VEC [NV] = '{
    {8'h55, 1'b0, 6'h02, 32'h0000_3412, 8'h00, 4'h0, 1'b1},
    {8'h55, 1'b0, 6'h03, 32'h0080_01FF, 8'h00, 4'h0, 1'b1},
    {8'h55, 1'b0, 6'h01, 32'h0000_00A5, 8'hFF, 4'h8, 1'b0},
    {8'h55, 1'b1, 6'h04, 32'h4433_2211, 8'h00, 4'h4, 1'b0},
    {8'h54, 1'b0, 6'h02, 32'h0000_2211, 8'h00, 4'h2, 1'b0},
    {8'h55, 1'b0, 6'h0C, 32'hDDCC_BBAA, 8'h00, 4'h0, 1'b1}
  };

  function automatic logic [7:0] mk_pid(input logic [5:0] id, input logic bad);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1 ^ bad, p0, id};
  endfunction

  function automatic logic [7:0] cks_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    #1;
    got_tx = tx_valid; got_b = tx_byte; got_id = lk_id;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic brk(input logic ok);
    @(negedge clk);
    brk_seen = 1'b1; brk_ok = ok;
    @(posedge clk); #1;
    brk_seen = 1'b0; brk_ok = 1'b0;
    @(negedge clk);
  endtask

  task automatic wake();
    @(negedge clk);
    wake_req = 1'b1;
    #1;
    got_tx = tx_valid; got_b = tx_byte;
    @(posedge clk); #1;
    wake_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr_all();
    @(negedge clk);
    err_clr = 1'b1; done_clr = 1'b1;
    @(posedge clk); #1;
    err_clr = 1'b0; done_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [7:0] sum, ckb;
    int len;
    rst_n = 1'b0; brk_seen = 1'b0; brk_ok = 1'b0; rx_valid = 1'b0; rx_byte = '0;
    bus_asleep = 1'b0; wake_req = 1'b0; err_clr = 1'b0; done_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset err_flags", err_flags, 0);
    check("R10 reset busy", busy, 0);
    check("R7 reset done flags", {rx_done, tx_done}, 0);
    check("R9 reset tx_valid", tx_valid, 0);

    // table of receive frames
    for (int v = 0; v < NV; v++) begin
      clr_all();
      brk(1'b1);
      send(VEC[v][59:52]);
      send(mk_pid(VEC[v][50:45], VEC[v][51]));
      len = int'(VEC[v][47:45]);
      sum = 8'h00;
      for (int i = 0; i < len; i++) begin
        send(VEC[v][13 + 8*i +: 8]);
        sum = cks_add(sum, VEC[v][13 + 8*i +: 8]);
      end
      ckb = ~sum ^ VEC[v][12:5];
      send(ckb);
      check("R2 R3 R5 R11 vector err_flags", err_flags, VEC[v][4:1]);
      check("R5 R7 vector rx_done", rx_done, VEC[v][0]);
      check("R10 vector busy back to idle", busy, 0);
      if (VEC[v][0]) begin
        for (int i = 0; i < len; i++)
          check("R5 buffer contents", mem[i], VEC[v][13 + 8*i +: 8]);
      end
    end

    // done flag sticky until done_clr (last vector completed)
    repeat (5) @(negedge clk);
    check("R7 rx_done holds", rx_done, 1);
    @(negedge clk); done_clr = 1'b1; @(posedge clk); #1; done_clr = 1'b0; @(negedge clk);
    check("R7 rx_done cleared", rx_done, 0);

    // transmit frame: id 0x22, two bytes from buffer (AA, BB)
    clr_all();
    brk(1'b1);
    check("R10 busy after break", busy, 1);
    send(8'h55);
    send(mk_pid(6'h22, 1'b0));
    check("R4 lk_id", got_id, 6'h22);
    check("R6 first tx byte", {got_tx, got_b}, {1'b1, 8'hAA});
    send(8'hAA);
    check("R6 second tx byte", {got_tx, got_b}, {1'b1, 8'hBB});
    sum = cks_add(8'hAA, 8'hBB);
    send(8'hBB);
    check("R6 R11 tx checksum", {got_tx, got_b}, {1'b1, ~sum});
    send(~sum);
    check("R6 no tx after checksum echo", got_tx, 0);
    check("R7 tx_done", tx_done, 1);
    check("R1 no error on matching echo", err_flags, 0);
    check("R10 idle after tx frame", busy, 0);

    // readback mismatch
    clr_all();
    brk(1'b1);
    send(8'h55);
    send(mk_pid(6'h21, 1'b0));
    send(8'hAB);
    check("R1 bit error on echo mismatch", err_flags, 4'h1);
    check("R1 idle after bit error", busy, 0);

    // errors block traffic
    brk(1'b1);
    check("R8 break ignored while error", busy, 0);
    send(8'h55);
    send(mk_pid(6'h21, 1'b0));
    check("R8 no transmit while error", got_tx, 0);
    bus_asleep = 1'b1;
    wake();
    check("R8 wake blocked while error", got_tx, 0);
    check("R8 error still set", err_flags, 4'h1);
    bus_asleep = 1'b0;
    clr_all();
    check("R8 err_clr clears", err_flags, 0);

    // zero-length lookup
    brk(1'b1);
    send(8'h55);
    send(mk_pid(6'h08, 1'b0));
    check("R4 lk_id zero length", got_id, 6'h08);
    check("R4 zero length ends frame", {busy, err_flags, rx_done, tx_done, got_tx}, 0);

    // invalid break
    brk(1'b0);
    check("R2 invalid break sync error", err_flags, 4'h2);
    check("R2 invalid break not busy", busy, 0);
    clr_all();

    // wake-up
    wake();
    check("R9 no wake when awake", got_tx, 0);
    bus_asleep = 1'b1;
    wake();
    check("R9 wake char sent", {got_tx, got_b}, {1'b1, 8'h80});
    check("R10 busy during wake", busy, 1);
    send(8'h80);
    check("R9 wake echo ok", {busy, err_flags}, 0);
    bus_asleep = 1'b0;

    report();
    $finish;
  end
endmodule